// File: doc/BRIEF.md
# Flash-to-RAM Overlay Address Remapper

This block sits on a 24-bit CPU address path in front of the on-chip flash and RAM. When its overlay is enabled, an access to one chosen 4 KB block in the low 32 KB of flash goes to a fixed 4 KB window of on-chip RAM instead. Software can then change that RAM and see the new values at flash addresses, so flash constants can be tuned while the code runs. When the overlay is released, those addresses map to flash again. The RAM window can also still be reached at its own addresses.

A small control register holds an overlay enable flag and a 3-bit block number. While the overlay is enabled, the block blocks the program-mode and erase-mode requests to the flash controller for every block, and it drives a status pin that shows this protection. Address decoding is combinational. The port has no data stream and no handshake: `cpu_req` qualifies an access in the same cycle, and nothing can stall it. There is no back-pressure.

Top module: `ovl_remap`

## Requirements
- R1: After reset the register reads 0, the overlay is off, `emu_protect` is low, and flash addresses select flash.
- R2: A write with `cfg_we` high loads `cfg_wdata` (bit 3 = overlay enable, bits 2:0 = block number n). The value reads back on `cfg_rdata` after the clock edge.
- R3: With the overlay on, a request whose address lies in n*0x1000 to n*0x1000+0xFFF asserts `ram_cs` and not `flash_cs`. `mem_addr` is then 0xFFDC00 plus address bits 11:0.
- R4: A request in 0xFFDC00 to 0xFFFBFF always asserts `ram_cs` with `mem_addr` equal to the CPU address, whether the overlay is on or off.
- R5: While the overlay enable is set, `emu_protect` is high and `prog_go` and `erase_go` stay low for any block number. While it is clear, each go output follows its request.
- R6: Flash addresses outside the selected block are never remapped. This includes every address from 0x08000 to 0x3FFFF. Such an access asserts `flash_cs` with `mem_addr` equal to the CPU address.
- R7: After the enable is cleared, the block that was selected maps to flash again.
- R8: Block number 0 remaps addresses 0x00000 to 0x00FFF, which hold the vector table, onto the RAM window.
- R9: With `cpu_req` low, or with an address in neither region, both chip selects are low.
- R10: The mapping follows the register contents from the clock edge that loads a write. In the cycle of the write itself, the old mapping still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Write value: bit 3 enable, bits 2:0 block number |
| cfg_rdata | output | 4 | Current register value |
| cpu_req | input | 1 | Access request for this cycle |
| cpu_addr | input | 24 | CPU address |
| flash_cs | output | 1 | Flash chip select |
| ram_cs | output | 1 | RAM chip select |
| mem_addr | output | 24 | Address to the selected memory |
| prog_req | input | 1 | Program-mode request from the flash control register |
| erase_req | input | 1 | Erase-mode request from the flash control register |
| prog_go | output | 1 | Program-mode request passed to the flash controller |
| erase_go | output | 1 | Erase-mode request passed to the flash controller |
| emu_protect | output | 1 | High while program and erase are blocked by the overlay |

## Verification
The assertions assume `rst_n` is asserted from time zero and that every input is a known 0 or 1 at each clock edge. They also assume `cpu_addr` and the request pins change only between edges. The bench meets this by holding reset from the start and driving every input on the falling edge. It gives every input a defined value before reset is released and never leaves an input floating.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int OVL_SEL_W = 3;

  typedef struct packed {
    logic                 en;
    logic [OVL_SEL_W-1:0] sel;
  } ovl_cfg_t;

  localparam int OVL_CFG_W = $bits(ovl_cfg_t);
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
  import ovl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [OVL_CFG_W-1:0] wdata,
  output ovl_cfg_t             cfg,
  output logic [OVL_CFG_W-1:0] rdata
);
  ovl_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (we) cfg_q <= ovl_cfg_t'(wdata);
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_q;

  // R2: a write is visible on the read port after the edge
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == $past(wdata));
  // R2: without a write the register holds
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter int              BLK_AW     = 12,
  parameter logic [ADDR_W-1:0] FLASH_LAST = 24'h03FFFF,
  parameter logic [ADDR_W-1:0] RAM_FIRST  = 24'hFFDC00,
  parameter logic [ADDR_W-1:0] RAM_LAST   = 24'hFFFBFF,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 24'hFFDC00
)(
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  ovl_cfg_t          cfg,
  output logic              flash_cs,
  output logic              ram_cs,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int TOP_LSB = BLK_AW + OVL_SEL_W;

  logic              in_ovl_area;
  logic              blk_match;
  logic              hit;
  logic              in_flash;
  logic              in_ram;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    in_ovl_area = (cpu_addr[ADDR_W-1:TOP_LSB] == '0);
    blk_match   = (cpu_addr[TOP_LSB-1:BLK_AW] == cfg.sel);
    hit         = cfg.en && in_ovl_area && blk_match;
    in_flash    = (cpu_addr <= FLASH_LAST);
    in_ram      = (cpu_addr >= RAM_FIRST) && (cpu_addr <= RAM_LAST);
    offset      = '0;
    offset[BLK_AW-1:0] = cpu_addr[BLK_AW-1:0];
    mem_addr    = hit ? (WIN_BASE + offset) : cpu_addr;
    ram_cs      = cpu_req && (hit || in_ram);
    flash_cs    = cpu_req && in_flash && !hit;
  end
endmodule

// File: rtl/ovl_pe_guard.sv
module ovl_pe_guard #(
  parameter int NUM_REQ = 2
)(
  input  logic               protect,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] go
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_gate
    assign go[g] = req[g] && !protect;
  end
endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
  import ovl_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter int              BLK_AW     = 12,
  parameter logic [ADDR_W-1:0] FLASH_LAST = 24'h03FFFF,
  parameter logic [ADDR_W-1:0] RAM_FIRST  = 24'hFFDC00,
  parameter logic [ADDR_W-1:0] RAM_LAST   = 24'hFFFBFF,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 24'hFFDC00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              flash_cs,
  output logic              ram_cs,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              prog_req,
  input  logic              erase_req,
  output logic              prog_go,
  output logic              erase_go,
  output logic              emu_protect
);
  localparam int          BLK_SIZE = 1 << BLK_AW;
  localparam int          NUM_BLK  = 1 << OVL_SEL_W;
  localparam logic [ADDR_W-1:0] OVL_LAST = ADDR_W'(NUM_BLK * BLK_SIZE - 1);
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(BLK_SIZE - 1);

  ovl_cfg_t   cfg;
  logic [1:0] pe_go;

  ovl_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  ovl_decode #(
    .ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .FLASH_LAST(FLASH_LAST),
    .RAM_FIRST(RAM_FIRST), .RAM_LAST(RAM_LAST), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .cpu_req  (cpu_req),
    .cpu_addr (cpu_addr),
    .cfg      (cfg),
    .flash_cs (flash_cs),
    .ram_cs   (ram_cs),
    .mem_addr (mem_addr)
  );

  assign emu_protect = cfg.en;

  ovl_pe_guard #(.NUM_REQ(2)) u_guard (
    .protect (emu_protect),
    .req     ({erase_req, prog_req}),
    .go      (pe_go)
  );
  assign prog_go  = pe_go[0];
  assign erase_go = pe_go[1];

  // R9: the two memories are never selected together, and nothing is selected without a request
  p_cs_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_cs && ram_cs));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> (!flash_cs && !ram_cs));
  // R3: a remapped access lands inside the RAM window
  p_win_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && (cpu_addr <= OVL_LAST) && ram_cs)
      |-> (mem_addr >= WIN_BASE) && (mem_addr <= WIN_LAST));
  // R6: flash above the overlay area passes through
  p_high_flash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && (cpu_addr > OVL_LAST) && (cpu_addr <= FLASH_LAST))
      |-> (flash_cs && (mem_addr == cpu_addr)));
  // R7: with the overlay released, every flash address goes to flash
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[3] && cpu_req && (cpu_addr <= FLASH_LAST)) |-> flash_cs);
  // R5: program and erase are blocked while protection is shown
  p_pe_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emu_protect |-> (!prog_go && !erase_go));
  p_pe_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_protect |-> ((prog_go == prog_req) && (erase_go == erase_req)));
endmodule

// File: tb/sim_ovl_remap.sv
module sim_ovl_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_rdata;
  logic        cpu_req = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        flash_cs, ram_cs;
  logic [23:0] mem_addr;
  logic        prog_req = 1'b0, erase_req = 1'b0;
  logic        prog_go, erase_go, emu_protect;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ovl_remap u0 (.*);

  typedef struct packed {
    logic [3:0]  cfg;
    logic [23:0] addr;
    logic        fcs;
    logic        rcs;
    logic [23:0] exp_addr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 24'h001234, 1'b1, 1'b0, 24'h001234, 8'd7},  // R7 overlay off
    '{4'h9, 24'h001234, 1'b0, 1'b1, 24'hFFDE34, 8'd3},  // R3 block 1
    '{4'h9, 24'h001FFF, 1'b0, 1'b1, 24'hFFEBFF, 8'd3},  // R3 block top
    '{4'h9, 24'h002000, 1'b1, 1'b0, 24'h002000, 8'd6},  // R6 next block
    '{4'h9, 24'h000FFF, 1'b1, 1'b0, 24'h000FFF, 8'd6},  // R6 previous block
    '{4'h9, 24'h03FFFF, 1'b1, 1'b0, 24'h03FFFF, 8'd6},  // R6 flash top
    '{4'h9, 24'hFFDE34, 1'b0, 1'b1, 24'hFFDE34, 8'd4},  // R4 own address
    '{4'hF, 24'h007ABC, 1'b0, 1'b1, 24'hFFE6BC, 8'd3},  // R3 block 7
    '{4'hF, 24'h00F123, 1'b1, 1'b0, 24'h00F123, 8'd6},  // R6 above area
    '{4'h8, 24'h000004, 1'b0, 1'b1, 24'hFFDC04, 8'd8},  // R8 vector area
    '{4'h8, 24'hFFFBFF, 1'b0, 1'b1, 24'hFFFBFF, 8'd4},  // R4 ram top
    '{4'h1, 24'h001234, 1'b1, 1'b0, 24'h001234, 8'd7},  // R7 select kept, off
    '{4'h0, 24'h040000, 1'b0, 1'b0, 24'h040000, 8'd9},  // R9 unmapped
    '{4'h0, 24'hFFFC00, 1'b0, 1'b0, 24'hFFFC00, 8'd9},  // R9 past ram
    '{4'h8, 24'h105000, 1'b0, 1'b0, 24'h105000, 8'd9}   // R9 high alias
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cpu_req = 1'b1; cpu_addr = 24'h001234; #1;
    check("R1 rdata", 32'(cfg_rdata), 32'h0);
    check("R1 protect", 32'(emu_protect), 32'h0);
    check("R1 flash_cs", 32'({flash_cs, ram_cs}), 32'b10);

    for (int i = 0; i < NV; i++) begin
      if (cfg_rdata !== VEC[i].cfg) write_cfg(VEC[i].cfg);
      @(negedge clk);
      cpu_req = 1'b1; cpu_addr = VEC[i].addr; #1;
      check($sformatf("R%0d vec%0d cs", VEC[i].req, i),
            32'({flash_cs, ram_cs}), 32'({VEC[i].fcs, VEC[i].rcs}));
      check($sformatf("R%0d vec%0d addr", VEC[i].req, i),
            32'(mem_addr), 32'(VEC[i].exp_addr));
    end

    // R2 readback
    write_cfg(4'hA); #1;
    check("R2 rdata", 32'(cfg_rdata), 32'hA);

    // R5 protection for several block numbers
    prog_req = 1'b1; erase_req = 1'b1; #1;
    check("R5 go sel2", 32'({prog_go, erase_go, emu_protect}), 32'b001);
    write_cfg(4'h8); #1;
    check("R5 go sel0", 32'({prog_go, erase_go, emu_protect}), 32'b001);
    write_cfg(4'h0); #1;
    check("R5 go off", 32'({prog_go, erase_go, emu_protect}), 32'b110);
    erase_req = 1'b0; #1;
    check("R5 erase only off", 32'({prog_go, erase_go}), 32'b10);
    prog_req = 1'b0;

    // R10 timing of a write
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 24'h003010;
    cfg_we = 1'b1; cfg_wdata = 4'hB; #1;
    check("R10 before edge", 32'({flash_cs, ram_cs}), 32'b10);
    @(negedge clk);
    cfg_we = 1'b0; #1;
    check("R10 after edge", 32'({flash_cs, ram_cs}), 32'b01);
    check("R10 addr", 32'(mem_addr), 32'hFFDC10);

    // R9 no request
    cpu_req = 1'b0; #1;
    check("R9 idle", 32'({flash_cs, ram_cs}), 32'b00);

    // R1 reset clears register again
    rst_n = 1'b0; #1;
    check("R1 async reset", 32'({cfg_rdata, emu_protect}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule